// File: doc/BRIEF.md
# Program Counter Sequencer with Skip

This block owns the 13-bit instruction address of a small two-cycle-branch microcontroller. One clock is one instruction cycle. In each cycle it takes the decoded class of the executing instruction, the ALU result and its zero flag, the page latch value and the top-of-stack word. From these it registers the address of the next fetch.

Any change of control flow means the instruction already fetched behind it is wrong. These changes are a jump, a call, a return, a write to the low address byte, a taken conditional skip and interrupt entry. For each of them the block raises a registered flush flag for exactly one cycle, and the core executes the fetched instruction in that slot as a NOP. The block also keeps a saved-address register for the stack to push, with a push strobe that accompanies calls and interrupt entry. While the core sleeps, the address is frozen, so the fetched instruction runs on wake-up.

The instruction class is a 3-bit code: 0 plain, 1 jump (goto), 2 call, 3 return (any of the three return kinds), 4 skip-if-zero, 5 skip-if-nonzero. Codes 6 and 7 behave as plain.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` and `old_pc_o` become 0 and `flush_o` and `push_o` become 0.
- R2: Priority at each edge is reset, then interrupt, then sleep hold, then normal next-address selection.
- R3: With `irq_i` high (no reset), `old_pc_o` takes the current `pc_o`, `pc_o` becomes 0x004, and `flush_o` and `push_o` are 1 in the following cycle.
- R4: Class 3 (return) loads `pc_o` from `tos_i` and sets `flush_o`.
- R5: Class 1 (jump) and class 2 (call) load `pc_o` with {`pclath_i`[4:3], `addr_i`[10:0]} and set `flush_o`. A call also loads `old_pc_o` with the current `pc_o` + 1 and sets `push_o`.
- R6: With `pcl_wr_i` high and a class other than 1, 2 or 3, `pc_o` becomes {`pclath_i`[4:0], `alu_res_i`[7:0]} and `flush_o` is set. Jump, call and return take precedence over the write.
- R7: With no other condition, `pc_o` becomes `pc_o` + 1 (wrapping at 13 bits), `flush_o` and `push_o` are 0, and `old_pc_o` holds.
- R8: Class 4 with `alu_zero_i`=1, or class 5 with `alu_zero_i`=0, advances `pc_o` by one and sets `flush_o`. In the opposite case the class behaves as plain.
- R9: With `sleep_i` high (no reset, no interrupt), `pc_o` and `old_pc_o` hold and `flush_o` and `push_o` are 0, whatever the class inputs carry.
- R10: `push_o` is high for exactly the one cycle after an accepted call or interrupt, and low otherwise.
- R11: The instruction presented while `flush_o` is 1 is treated as plain: `pc_o` + 1, no flush, no push, and `pcl_wr_i` is ignored. An interrupt is still taken in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 3 | Decoded instruction class code |
| addr_i | input | 11 | Address field of jump/call |
| pcl_wr_i | input | 1 | Instruction writes the low address byte |
| alu_res_i | input | 8 | ALU result |
| alu_zero_i | input | 1 | ALU result is zero |
| pclath_i | input | 5 | Page latch register value |
| tos_i | input | 13 | Top-of-stack return address |
| irq_i | input | 1 | Interrupt entry request |
| sleep_i | input | 1 | Sleep in effect, freeze address |
| pc_o | output | 13 | Current fetch address |
| old_pc_o | output | 13 | Saved address for the stack push |
| flush_o | output | 1 | Execute the fetched instruction as NOP |
| push_o | output | 1 | Push `old_pc_o` onto the stack |

## Verification
The hardest case to reach is the flushed slot. A control transfer has to be followed at once by a second transfer-type instruction, a PCL write or an interrupt, so that the slot-kill path decides the result. The stimulus chains a jump directly into another jump, a call into a PCL write, and an interrupt into a second interrupt. It also holds sleep while jump and interrupt inputs toggle, and asserts reset together with an interrupt to exercise the full priority order.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN    = 3'd0,
    CLS_JUMP     = 3'd1,
    CLS_CALL     = 3'd2,
    CLS_RETURN   = 3'd3,
    CLS_SKIP_Z   = 3'd4,
    CLS_SKIP_NZ  = 3'd5
  } pc_cls_e;

  typedef enum logic [1:0] {
    ACT_RESET = 2'd0,
    ACT_IRQ   = 2'd1,
    ACT_HOLD  = 2'd2,
    ACT_RUN   = 2'd3
  } pc_act_e;

endpackage

// File: rtl/pcseq_skip_eval.sv
module pcseq_skip_eval
  import pcseq_pkg::*;
(
  input  pc_cls_e cls,
  input  logic    alu_zero,
  output logic    skip_taken
);

  always_comb begin
    unique case (cls)
      CLS_SKIP_Z:  skip_taken = alu_zero;
      CLS_SKIP_NZ: skip_taken = ~alu_zero;
      default:     skip_taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcseq_target_sel.sv
module pcseq_target_sel
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8,
  localparam int LATCH_W = PC_W - DATA_W,
  localparam int PAGE_W  = PC_W - JMP_W
) (
  input  pc_cls_e            cls,
  input  logic               pcl_wr,
  input  logic               skip_taken,
  input  logic [PC_W-1:0]    pc,
  input  logic [JMP_W-1:0]   addr,
  input  logic [DATA_W-1:0]  alu_res,
  input  logic [LATCH_W-1:0] pclath,
  input  logic [PC_W-1:0]    tos,
  output logic [PC_W-1:0]    next_pc,
  output logic [PC_W-1:0]    ret_addr,
  output logic               redirect,
  output logic               is_call
);

  logic [PC_W-1:0] jump_tgt;
  logic [PC_W-1:0] calc_tgt;
  logic [PC_W-1:0] seq_tgt;

  // Page bits for jumps come from the upper latch bits.
  generate
    if (PAGE_W > 0) begin : g_paged
      assign jump_tgt = {pclath[LATCH_W-1 -: PAGE_W], addr};
    end else begin : g_flat
      assign jump_tgt = addr[PC_W-1:0];
    end
  endgenerate

  assign calc_tgt = {pclath, alu_res};
  assign seq_tgt  = pc + PC_W'(1);
  assign ret_addr = seq_tgt;

  always_comb begin
    next_pc  = seq_tgt;
    redirect = 1'b0;
    is_call  = 1'b0;
    unique case (cls)
      CLS_JUMP: begin
        next_pc  = jump_tgt;
        redirect = 1'b1;
      end
      CLS_CALL: begin
        next_pc  = jump_tgt;
        redirect = 1'b1;
        is_call  = 1'b1;
      end
      CLS_RETURN: begin
        next_pc  = tos;
        redirect = 1'b1;
      end
      default: begin
        if (pcl_wr) begin
          next_pc  = calc_tgt;
          redirect = 1'b1;
        end else begin
          redirect = skip_taken;
        end
      end
    endcase
  end

endmodule

// File: rtl/pcseq_state.sv
module pcseq_state
  import pcseq_pkg::*;
#(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq,
  input  logic            sleep,
  input  logic [PC_W-1:0] next_pc,
  input  logic [PC_W-1:0] ret_addr,
  input  logic            redirect,
  input  logic            is_call,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] old_q,
  output logic            flush_q,
  output logic            push_q
);

  pc_act_e act;

  always_comb begin
    if (rst)        act = ACT_RESET;
    else if (irq)   act = ACT_IRQ;
    else if (sleep) act = ACT_HOLD;
    else            act = ACT_RUN;
  end

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_RESET: begin
        pc_q    <= '0;
        old_q   <= '0;
        flush_q <= 1'b0;
        push_q  <= 1'b0;
      end
      ACT_IRQ: begin
        old_q   <= pc_q;
        pc_q    <= VECTOR;
        flush_q <= 1'b1;
        push_q  <= 1'b1;
      end
      ACT_HOLD: begin
        flush_q <= 1'b0;
        push_q  <= 1'b0;
      end
      default: begin
        pc_q    <= next_pc;
        flush_q <= redirect;
        push_q  <= is_call;
        if (is_call) old_q <= ret_addr;
      end
    endcase
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W   = 13,
  parameter int JMP_W  = 11,
  parameter int DATA_W = 8,
  parameter logic [PC_W-1:0] VECTOR = 13'h004,
  localparam int LATCH_W = PC_W - DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         cls_i,
  input  logic [JMP_W-1:0]   addr_i,
  input  logic               pcl_wr_i,
  input  logic [DATA_W-1:0]  alu_res_i,
  input  logic               alu_zero_i,
  input  logic [LATCH_W-1:0] pclath_i,
  input  logic [PC_W-1:0]    tos_i,
  input  logic               irq_i,
  input  logic               sleep_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    old_pc_o,
  output logic               flush_o,
  output logic               push_o
);

  pc_cls_e         eff_cls;
  logic            eff_pcl_wr;
  logic            skip_taken;
  logic [PC_W-1:0] next_pc;
  logic [PC_W-1:0] ret_addr;
  logic            redirect;
  logic            is_call;

  // The slot behind a control change runs as a NOP.
  assign eff_cls    = flush_o ? CLS_PLAIN : pc_cls_e'(cls_i);
  assign eff_pcl_wr = pcl_wr_i & ~flush_o;

  pcseq_skip_eval u_skip (
    .cls        (eff_cls),
    .alu_zero   (alu_zero_i),
    .skip_taken (skip_taken)
  );

  pcseq_target_sel #(
    .PC_W   (PC_W),
    .JMP_W  (JMP_W),
    .DATA_W (DATA_W)
  ) u_sel (
    .cls        (eff_cls),
    .pcl_wr     (eff_pcl_wr),
    .skip_taken (skip_taken),
    .pc         (pc_o),
    .addr       (addr_i),
    .alu_res    (alu_res_i),
    .pclath     (pclath_i),
    .tos        (tos_i),
    .next_pc    (next_pc),
    .ret_addr   (ret_addr),
    .redirect   (redirect),
    .is_call    (is_call)
  );

  pcseq_state #(
    .PC_W   (PC_W),
    .VECTOR (VECTOR)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq_i),
    .sleep    (sleep_i),
    .next_pc  (next_pc),
    .ret_addr (ret_addr),
    .redirect (redirect),
    .is_call  (is_call),
    .pc_q     (pc_o),
    .old_q    (old_pc_o),
    .flush_q  (flush_o),
    .push_q   (push_o)
  );

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cls_i,
  input logic            pcl_wr_i,
  input logic            irq_i,
  input logic            sleep_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] old_pc_o,
  input logic            flush_o,
  input logic            push_o
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: outputs cleared the cycle after reset
  always @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      p_reset_clear_r1: assert (pc_o == '0 && old_pc_o == '0 && !flush_o && !push_o)
        else $error("reset state wrong");
    end
  end

  // R3
  p_irq_vector_r3: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> (pc_o == VECTOR && flush_o && push_o));

  // R3
  p_irq_save_r3: assert property (@(posedge clk) disable iff (rst)
    irq_i |=> (old_pc_o == $past(pc_o)));

  // R9
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !irq_i) |=> ($stable(pc_o) && $stable(old_pc_o) && !flush_o && !push_o));

  // R11
  p_flush_single_r11: assert property (@(posedge clk) disable iff (rst)
    (flush_o && !irq_i) |=> !flush_o);

  // R10
  p_push_source_r10: assert property (@(posedge clk) disable iff (rst)
    (!irq_i && (sleep_i || cls_i != 3'd2 || flush_o)) |=> !push_o);

  // R7
  p_increment_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_i && !sleep_i && !pcl_wr_i && cls_i == 3'd0) |=> (pc_o == $past(pc_o) + PC_W'(1) && !flush_o));

endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cls_i    (cls_i),
  .pcl_wr_i (pcl_wr_i),
  .irq_i    (irq_i),
  .sleep_i  (sleep_i),
  .pc_o     (pc_o),
  .old_pc_o (old_pc_o),
  .flush_o  (flush_o),
  .push_o   (push_o)
);

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cls_i = '0;
  logic [10:0] addr_i = '0;
  logic        pcl_wr_i = 1'b0;
  logic [7:0]  alu_res_i = '0;
  logic        alu_zero_i = 1'b0;
  logic [4:0]  pclath_i = '0;
  logic [12:0] tos_i = '0;
  logic        irq_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic [12:0] pc_o, old_pc_o;
  logic        flush_o, push_o;

  always #10 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .cls_i(cls_i), .addr_i(addr_i), .pcl_wr_i(pcl_wr_i),
    .alu_res_i(alu_res_i), .alu_zero_i(alu_zero_i), .pclath_i(pclath_i),
    .tos_i(tos_i), .irq_i(irq_i), .sleep_i(sleep_i),
    .pc_o(pc_o), .old_pc_o(old_pc_o), .flush_o(flush_o), .push_o(push_o)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  // reference state, built from the requirements
  logic [12:0] m_pc = '0, m_old = '0;
  logic        m_fl = 0, m_pu = 0;

  task automatic step(input logic r, input logic [2:0] c, input logic [10:0] a,
                      input logic w, input logic [7:0] alu, input logic z,
                      input logic [4:0] lat, input logic [12:0] tos,
                      input logic irq, input logic slp, input string tag);
    logic [2:0] ec;
    logic ew;
    @(negedge clk);
    rst = r; cls_i = c; addr_i = a; pcl_wr_i = w; alu_res_i = alu;
    alu_zero_i = z; pclath_i = lat; tos_i = tos; irq_i = irq; sleep_i = slp;
    if (r) begin
      m_pc = '0; m_old = '0; m_fl = 0; m_pu = 0;
    end else if (irq) begin
      m_old = m_pc; m_pc = 13'h004; m_fl = 1; m_pu = 1;
    end else if (slp) begin
      m_fl = 0; m_pu = 0;
    end else begin
      ec = m_fl ? 3'd0 : c;
      ew = m_fl ? 1'b0 : w;
      m_pu = 0;
      case (ec)
        3'd1: begin m_pc = {lat[4:3], a}; m_fl = 1; end
        3'd2: begin m_old = m_pc + 13'd1; m_pc = {lat[4:3], a}; m_fl = 1; m_pu = 1; end
        3'd3: begin m_pc = tos; m_fl = 1; end
        default: begin
          if (ew) begin
            m_pc = {lat, alu}; m_fl = 1;
          end else begin
            m_fl = (ec == 3'd4 && z) || (ec == 3'd5 && !z);
            m_pc = m_pc + 13'd1;
          end
        end
      endcase
    end
    exp_q.push_back({m_pc, m_old, m_fl, m_pu});
    tag_q.push_back(tag);
  endtask

  task automatic plain(input string tag);
    step(0, 3'd0, 11'h0, 0, 8'h00, 0, 5'h00, 13'h0, 0, 0, tag);
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [27:0] e;
        logic [27:0] act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = {pc_o, old_pc_o, flush_o, push_o};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: pc=%h old=%h flush=%b push=%b expected pc=%h old=%h flush=%b push=%b",
                   t, pc_o, old_pc_o, flush_o, push_o, e[27:15], e[14:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(1, 3'd0, 11'h0, 0, 8'h0, 0, 5'h0, 13'h0, 0, 0, "R1 reset");
    step(1, 3'd1, 11'h7FF, 0, 8'h0, 0, 5'h1F, 13'h0, 1, 0, "R1 reset with inputs");
    plain("R7 increment 1");
    plain("R7 increment 2");
    plain("R7 increment 3");
    step(0, 3'd1, 11'h2AB, 0, 8'h0, 0, 5'h1A, 13'h0, 0, 0, "R5 jump paged");
    step(0, 3'd1, 11'h111, 0, 8'h0, 0, 5'h00, 13'h0, 0, 0, "R11 jump in flushed slot");
    step(0, 3'd2, 11'h055, 0, 8'h0, 0, 5'h08, 13'h0, 0, 0, "R5 R10 call");
    step(0, 3'd0, 11'h0, 1, 8'hAA, 0, 5'h03, 13'h0, 0, 0, "R11 pcl write ignored in slot");
    plain("R10 push drops");
    step(0, 3'd0, 11'h0, 1, 8'h3C, 0, 5'h1F, 13'h0, 0, 0, "R6 pcl write");
    plain("R11 slot after pcl write");
    step(0, 3'd3, 11'h0, 1, 8'h77, 0, 5'h1F, 13'h0123, 0, 0, "R4 R6 return beats pcl write");
    plain("R11 slot after return");
    step(0, 3'd4, 11'h0, 0, 8'h00, 1, 5'h0, 13'h0, 0, 0, "R8 skip zero taken");
    step(0, 3'd4, 11'h0, 0, 8'h00, 1, 5'h0, 13'h0, 0, 0, "R11 skip in slot");
    step(0, 3'd4, 11'h0, 0, 8'h05, 0, 5'h0, 13'h0, 0, 0, "R8 skip zero not taken");
    step(0, 3'd5, 11'h0, 0, 8'h05, 0, 5'h0, 13'h0, 0, 0, "R8 skip nonzero taken");
    plain("R11 slot after skip");
    step(0, 3'd5, 11'h0, 0, 8'h00, 1, 5'h0, 13'h0, 0, 0, "R8 skip nonzero not taken");
    step(0, 3'd2, 11'h0AA, 0, 8'h0, 0, 5'h10, 13'h0, 1, 0, "R3 R2 irq beats call");
    step(0, 3'd0, 11'h0, 0, 8'h0, 0, 5'h0, 13'h0, 1, 0, "R11 R3 irq in flushed slot");
    plain("R10 slot after irq");
    step(0, 3'd1, 11'h3FF, 0, 8'h0, 0, 5'h18, 13'h0, 0, 1, "R9 sleep ignores jump");
    step(0, 3'd2, 11'h3FF, 1, 8'h12, 0, 5'h18, 13'h0, 0, 1, "R9 sleep ignores call");
    step(0, 3'd0, 11'h0, 0, 8'h0, 0, 5'h0, 13'h0, 1, 1, "R2 irq beats sleep");
    step(0, 3'd0, 11'h0, 0, 8'h0, 0, 5'h0, 13'h0, 0, 1, "R9 sleep after irq");
    step(0, 3'd3, 11'h0, 0, 8'h0, 0, 5'h0, 13'h1FFF, 0, 0, "R4 return to top");
    plain("R7 wrap slot");
    plain("R7 wrap to zero");
    step(1, 3'd2, 11'h123, 0, 8'h0, 0, 5'h1F, 13'h0, 1, 1, "R2 R1 reset beats all");
    plain("R7 after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule